// File: doc/BRIEF.md
# E1 Spare-Bit Receive Extractor

This block follows an E1 receive framer that has already found frame alignment. The framer supplies one received bit per clock, together with the timeslot number, the bit position inside the timeslot and the parity of the frame counter. The block watches timeslot 0. It captures the byte from the even (alignment) frame and the byte from the following odd (non-alignment) frame. Both bytes are published to two host-readable registers at the same instant, once per double frame, and a sticky status flag is raised at that moment. The host then has one double-frame period to read both registers before they are overwritten.

A second path repeats every received bit on a link data output. It also produces a link clock that pulses only while the data output carries one of the spare (Sa) bit positions the host has enabled. External logic can therefore clock the chosen Sa bits straight off the link data line. A sync output marks the first bit of every timeslot 0, which is the international (Si) bit position.

Top module: `e1sa_rx_extract`

## Requirements
- R1: While reset is held, both capture registers read 0, and the status flag, link clock and sync output are low.
- R2: The alignment register holds the timeslot-0 byte of the most recent even frame (rx_odd_frame = 0). The first received bit (bit position 0) goes to register bit 7 and the last to bit 0. Bits are stored as received, with no check of the fixed pattern.
- R3: The non-alignment register holds the timeslot-0 byte of the odd frame that follows that even frame, in the same bit order and unfiltered.
- R4: Both registers change only on the clock edge that samples bit position 7 of timeslot 0 in an odd frame. The new values are visible in the following cycle, and the registers keep their values in every other cycle.
- R5: The status flag is set on the same edge that updates the registers.
- R6: The status flag is sticky. A one-cycle pulse on raf_clr clears it in the next cycle, provided no update happens on that edge.
- R7: If an update and a clear pulse fall on the same edge, the flag ends up set.
- R8: In an odd frame, bit positions 3 to 7 of timeslot 0 are Sa4 to Sa8. sa_enable[0] selects Sa4 and sa_enable[4] selects Sa8. lnk_clk is high for exactly one cycle, one cycle after each enabled Sa bit is received, and is low in all other cycles.
- R9: lnk_data repeats rx_data delayed by exactly one cycle, for every bit of every timeslot.
- R10: sync_si is high for one cycle, one cycle after bit position 0 of timeslot 0 in every frame, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 1 | Received serial bit |
| rx_odd_frame | input | 1 | Frame counter parity, 1 for the non-alignment frame |
| rx_ts | input | TS_W | Timeslot number of the current bit |
| rx_bitpos | input | 3 | Bit position inside the timeslot, 0 received first |
| sa_enable | input | SA_N | Per-Sa-bit enable for the link clock, bit 0 = Sa4 |
| raf_clr | input | 1 | Host write-one pulse that clears the status flag |
| fas_q | output | 8 | Captured alignment-frame byte |
| nfas_q | output | 8 | Captured non-alignment-frame byte |
| raf_flag | output | 1 | Sticky capture status flag |
| lnk_clk | output | 1 | Gated pulse that marks enabled Sa bits on lnk_data |
| lnk_data | output | 1 | Received data delayed one cycle |
| sync_si | output | 1 | Marks the Si bit of each frame |

## Verification
The bound checker checks on every cycle the relations between ports across one clock edge: the flag is set by an update, a lone clear removes it, the registers hold between updates, the link clock follows the enable mask only at Sa positions, the one-cycle data delay, and the sync pulse on the Si position. Only the bench scenarios can show the content of the registers. That covers the bit order, the pairing of the alignment byte with the following odd frame, unfiltered capture of a corrupted alignment pattern, and the sequence of Sa bits gathered on the link clock for each mask. The bench also shows the set-over-clear outcome on a shared edge and the read window across a full double frame.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;

    localparam int BYTE_W      = 8;
    localparam int BITPOS_W    = 3;
    localparam int SA_FIRST    = 3;   // bit position of Sa4 in the byte stream
    localparam int SA_COUNT    = 5;

    typedef logic [BYTE_W-1:0]   ts0_byte_t;
    typedef logic [BITPOS_W-1:0] bitpos_t;

    // Decoded position of the bit currently presented by the framer
    typedef struct packed {
        logic    in_ts0;     // bit belongs to timeslot 0
        logic    odd_frame;  // non-alignment frame of the pair
        logic    si_bit;     // first bit of timeslot 0
        logic    sa_bit;     // one of the spare bit positions
        logic    last_bit;   // final bit of timeslot 0
        bitpos_t sa_idx;     // 0 = Sa4 ... 4 = Sa8
    } slot_pos_t;

    function automatic logic is_sa_pos(input bitpos_t p);
        return (int'(p) >= SA_FIRST) && (int'(p) < SA_FIRST + SA_COUNT);
    endfunction

    function automatic bitpos_t sa_index(input bitpos_t p);
        return p - bitpos_t'(SA_FIRST);
    endfunction

endpackage

// File: rtl/e1sa_pos_decode.sv
module e1sa_pos_decode
    import e1sa_pkg::*;
#(
    parameter int TS_W = 5
) (
    input  logic            rx_odd_frame,
    input  logic [TS_W-1:0] rx_ts,
    input  bitpos_t         rx_bitpos,
    output slot_pos_t       pos
);

    always_comb begin
        pos.in_ts0    = (rx_ts == '0);
        pos.odd_frame = rx_odd_frame;
        pos.si_bit    = pos.in_ts0 && (rx_bitpos == '0);
        pos.sa_bit    = pos.in_ts0 && rx_odd_frame && is_sa_pos(rx_bitpos);
        pos.last_bit  = pos.in_ts0 && (rx_bitpos == bitpos_t'(BYTE_W - 1));
        pos.sa_idx    = sa_index(rx_bitpos);
    end

endmodule

// File: rtl/e1sa_ts0_capture.sv
module e1sa_ts0_capture
    import e1sa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_pos_t pos,
    input  logic      rx_data,
    input  logic      raf_clr,
    output ts0_byte_t fas_q,
    output ts0_byte_t nfas_q,
    output logic      raf_flag
);

    ts0_byte_t shift_q;
    ts0_byte_t fas_hold_q;
    ts0_byte_t byte_now;
    logic      pair_done;

    // Completed byte including the bit arriving this cycle
    assign byte_now  = {shift_q[BYTE_W-2:0], rx_data};
    assign pair_done = pos.last_bit && pos.odd_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q    <= '0;
            fas_hold_q <= '0;
        end else begin
            if (pos.in_ts0) begin
                shift_q <= byte_now;
            end
            if (pos.last_bit && !pos.odd_frame) begin
                fas_hold_q <= byte_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fas_q  <= '0;
            nfas_q <= '0;
        end else if (pair_done) begin
            fas_q  <= fas_hold_q;
            nfas_q <= byte_now;
        end
    end

    // Sticky flag: a capture wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) begin
            raf_flag <= 1'b0;
        end else if (pair_done) begin
            raf_flag <= 1'b1;
        end else if (raf_clr) begin
            raf_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/e1sa_link_gate.sv
module e1sa_link_gate
    import e1sa_pkg::*;
#(
    parameter int SA_N = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  slot_pos_t       pos,
    input  logic            rx_data,
    input  logic [SA_N-1:0] sa_enable,
    output logic            lnk_clk,
    output logic            lnk_data,
    output logic            sync_si
);

    logic [SA_N-1:0] sa_hit;

    for (genvar i = 0; i < SA_N; i++) begin : g_sa
        assign sa_hit[i] = pos.sa_bit && (pos.sa_idx == bitpos_t'(i)) && sa_enable[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lnk_clk  <= 1'b0;
            lnk_data <= 1'b0;
            sync_si  <= 1'b0;
        end else begin
            lnk_clk  <= |sa_hit;
            lnk_data <= rx_data;
            sync_si  <= pos.si_bit;
        end
    end

endmodule

// File: rtl/e1sa_rx_extract.sv
module e1sa_rx_extract
    import e1sa_pkg::*;
#(
    parameter int TS_W = 5,
    parameter int SA_N = SA_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_data,
    input  logic            rx_odd_frame,
    input  logic [TS_W-1:0] rx_ts,
    input  logic [2:0]      rx_bitpos,
    input  logic [SA_N-1:0] sa_enable,
    input  logic            raf_clr,
    output logic [7:0]      fas_q,
    output logic [7:0]      nfas_q,
    output logic            raf_flag,
    output logic            lnk_clk,
    output logic            lnk_data,
    output logic            sync_si
);

    slot_pos_t pos;

    e1sa_pos_decode #(.TS_W(TS_W)) u_decode (
        .rx_odd_frame (rx_odd_frame),
        .rx_ts        (rx_ts),
        .rx_bitpos    (rx_bitpos),
        .pos          (pos)
    );

    e1sa_ts0_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .pos      (pos),
        .rx_data  (rx_data),
        .raf_clr  (raf_clr),
        .fas_q    (fas_q),
        .nfas_q   (nfas_q),
        .raf_flag (raf_flag)
    );

    e1sa_link_gate #(.SA_N(SA_N)) u_link (
        .clk       (clk),
        .rst       (rst),
        .pos       (pos),
        .rx_data   (rx_data),
        .sa_enable (sa_enable),
        .lnk_clk   (lnk_clk),
        .lnk_data  (lnk_data),
        .sync_si   (sync_si)
    );

endmodule

// File: rtl/e1sa_rx_extract_chk.sv
module e1sa_rx_extract_chk #(
    parameter int TS_W = 5,
    parameter int SA_N = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            rx_data,
    input logic            rx_odd_frame,
    input logic [TS_W-1:0] rx_ts,
    input logic [2:0]      rx_bitpos,
    input logic [SA_N-1:0] sa_enable,
    input logic            raf_clr,
    input logic [7:0]      fas_q,
    input logic [7:0]      nfas_q,
    input logic            raf_flag,
    input logic            lnk_clk,
    input logic            lnk_data,
    input logic            sync_si
);

    logic       upd_evt;
    logic       sa_zone;
    logic       sa_on;
    logic [2:0] sa_k;

    assign upd_evt = (rx_ts == '0) && rx_odd_frame && (rx_bitpos == 3'd7);
    assign sa_zone = (rx_ts == '0) && rx_odd_frame && (rx_bitpos >= 3'd3);
    assign sa_k    = rx_bitpos - 3'd3;
    assign sa_on   = sa_zone && sa_enable[sa_k];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (fas_q == 8'h00 && nfas_q == 8'h00 && !raf_flag && !lnk_clk && !sync_si));

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        upd_evt |=> raf_flag);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (raf_clr && !upd_evt) |=> !raf_flag);

    // R4
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_evt |=> ($stable(fas_q) && $stable(nfas_q)));

    // R8
    lnk_on_chk: assert property (@(posedge clk) disable iff (rst)
        sa_on |=> lnk_clk);

    // R8
    lnk_off_chk: assert property (@(posedge clk) disable iff (rst)
        !sa_on |=> !lnk_clk);

    // R9
    lnk_data_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lnk_data == $past(rx_data)));

    // R10
    sync_si_chk: assert property (@(posedge clk) disable iff (rst)
        ((rx_ts == '0) && (rx_bitpos == 3'd0)) |=> sync_si);

    // R10
    sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !((rx_ts == '0) && (rx_bitpos == 3'd0)) |=> !sync_si);

endmodule

bind e1sa_rx_extract e1sa_rx_extract_chk #(.TS_W(TS_W), .SA_N(SA_N)) u_chk (.*);

// File: tb/e1sa_rx_extract_bench.sv
module e1sa_rx_extract_bench;

    localparam int TS_W = 5;
    localparam int SA_N = 5;

    logic            clk = 1'b0;
    logic            rst;
    logic            rx_data;
    logic            rx_odd_frame;
    logic [TS_W-1:0] rx_ts;
    logic [2:0]      rx_bitpos;
    logic [SA_N-1:0] sa_enable;
    logic            raf_clr;
    logic [7:0]      fas_q;
    logic [7:0]      nfas_q;
    logic            raf_flag;
    logic            lnk_clk;
    logic            lnk_data;
    logic            sync_si;

    always #10 clk = ~clk;

    e1sa_rx_extract #(.TS_W(TS_W), .SA_N(SA_N)) u_e1sa_rx_extract (
        .clk          (clk),
        .rst          (rst),
        .rx_data      (rx_data),
        .rx_odd_frame (rx_odd_frame),
        .rx_ts        (rx_ts),
        .rx_bitpos    (rx_bitpos),
        .sa_enable    (sa_enable),
        .raf_clr      (raf_clr),
        .fas_q        (fas_q),
        .nfas_q       (nfas_q),
        .raf_flag     (raf_flag),
        .lnk_clk      (lnk_clk),
        .lnk_data     (lnk_data),
        .sync_si      (sync_si)
    );

    int        checks = 0;
    int        errors = 0;
    int        fnum   = 0;
    logic [7:0] exp_fas  = 8'h00;
    logic [7:0] exp_nfas = 8'h00;
    logic      have_prev = 1'b0;
    logic      prev_d, prev_si, prev_lnk, prev_evt;
    logic [4:0] cap;
    int        ncap;
    int        sync_cnt;
    logic      finished = 1'b0;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One bit period: observe results of the previous drive, then drive anew
    task automatic tick(input logic d, input logic clr, input int ts,
                        input int b, input logic odd);
        @(negedge clk);
        if (have_prev) begin
            chk(lnk_data === prev_d, "R9", "lnk_data", int'(lnk_data), int'(prev_d));
            chk(sync_si === prev_si, "R10", "sync_si", int'(sync_si), int'(prev_si));
            chk(lnk_clk === prev_lnk, "R8", "lnk_clk", int'(lnk_clk), int'(prev_lnk));
            if (lnk_clk) begin
                cap = {cap[3:0], lnk_data};
                ncap++;
            end
            if (sync_si) sync_cnt++;
            if (prev_evt) begin
                chk(raf_flag === 1'b1, "R5", "flag at update", int'(raf_flag), 1);
                chk(fas_q === exp_fas, "R4", "fas at update", int'(fas_q), int'(exp_fas));
                chk(nfas_q === exp_nfas, "R4", "nfas at update", int'(nfas_q), int'(exp_nfas));
            end
        end
        rx_data      = d;
        raf_clr      = clr;
        rx_ts        = TS_W'(ts);
        rx_bitpos    = 3'(b);
        rx_odd_frame = odd;
        have_prev    = 1'b1;
        prev_d       = d;
        prev_si      = (ts == 0) && (b == 0);
        prev_lnk     = (ts == 0) && odd && (b >= 3) && sa_enable[b-3];
        prev_evt     = (ts == 0) && odd && (b == 7);
    endtask

    task automatic send_frame(input logic [7:0] ts0, input int clr_at);
        logic odd;
        odd = fnum[0];
        for (int ts = 0; ts < 32; ts++) begin
            for (int b = 0; b < 8; b++) begin
                logic d;
                d = (ts == 0) ? ts0[7-b] : logic'($urandom & 1);
                tick(d, (ts*8 + b) == clr_at, ts, b, odd);
            end
        end
        fnum++;
    endtask

    task automatic run_pair(input string name, input logic [7:0] fas, input logic [7:0] nfas,
                            input logic [4:0] mask, input int clr_even, input int clr_odd,
                            input logic flag_end);
        logic [4:0] ecap;
        int         ne;
        sa_enable = mask;
        cap = '0; ncap = 0; sync_cnt = 0;
        send_frame(fas, clr_even);
        // R4: an even frame alone leaves both registers untouched
        chk(fas_q === exp_fas, "R4", {name, " fas held"}, int'(fas_q), int'(exp_fas));
        chk(nfas_q === exp_nfas, "R4", {name, " nfas held"}, int'(nfas_q), int'(exp_nfas));
        if (clr_even >= 0)
            chk(raf_flag === 1'b0, "R6", {name, " flag cleared"}, int'(raf_flag), 0);
        exp_fas  = fas;
        exp_nfas = nfas;
        send_frame(nfas, clr_odd);
        chk(fas_q === fas, "R2", {name, " fas"}, int'(fas_q), int'(fas));
        chk(nfas_q === nfas, "R3", {name, " nfas"}, int'(nfas_q), int'(nfas));
        chk(raf_flag === flag_end, "R7", {name, " flag end"}, int'(raf_flag), int'(flag_end));
        ecap = '0; ne = 0;
        for (int i = 0; i < 5; i++) begin
            if (mask[i]) begin
                ecap = {ecap[3:0], nfas[4-i]};
                ne++;
            end
        end
        chk(ncap == ne, "R8", {name, " link pulses"}, ncap, ne);
        chk(cap === ecap, "R8", {name, " Sa bits"}, int'(cap), int'(ecap));
        chk(sync_cnt == 2, "R10", {name, " sync count"}, sync_cnt, 2);
    endtask

    task automatic t_reset;
        rst = 1'b1; rx_data = 0; rx_odd_frame = 0; rx_ts = '0; rx_bitpos = '0;
        sa_enable = '0; raf_clr = 0;
        repeat (3) @(negedge clk);
        chk(fas_q === 8'h00 && nfas_q === 8'h00, "R1", "regs in reset",
            int'({fas_q, nfas_q}), 0);
        chk(!raf_flag && !lnk_clk && !sync_si, "R1", "flags in reset",
            int'({raf_flag, lnk_clk, sync_si}), 0);
        rst = 1'b0;
    endtask

    task automatic t_basic;
        run_pair("basic", 8'h1B, 8'h5A, 5'b11111, -1, -1, 1'b1);
    endtask

    task automatic t_raw;
        // R2: corrupted alignment pattern is still reported as received
        run_pair("raw", 8'hE4, 8'h40, 5'b00000, -1, -1, 1'b1);
    endtask

    task automatic t_masks;
        logic [4:0] m [4] = '{5'b00001, 5'b10000, 5'b10101, 5'b01110};
        for (int i = 0; i < 4; i++) begin
            logic [7:0] nf;
            nf = 8'($urandom) | 8'h40;
            run_pair("mask", 8'h9B, nf, m[i], -1, -1, 1'b1);
        end
    endtask

    task automatic t_clear;
        // R6: clear after the update leaves the flag low at the end of the pair
        run_pair("clear", 8'h1B, 8'($urandom), 5'b01010, -1, 100, 1'b0);
    endtask

    task automatic t_collision;
        // R7: clear on the update edge loses to the new capture
        run_pair("collide", 8'h9B, 8'($urandom), 5'b11001, 100, 7, 1'b1);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_raw();
        t_masks();
        t_clear();
        t_collision();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule